// File: doc/BRIEF.md
# Predicated Instruction Decode and Effective-Value Unit

This block is the combinational front of an instruction decode stage for a machine with one 32-bit word per instruction. It cuts the instruction word into its condition predicate, operation code, destination and source register numbers and the immediate operand. A one-bit format select picks between the standard layout (register source plus a 16-bit operand) and the long layout (a 20-bit operand with no source register).

In the same pass it decides whether the instruction is to execute, by testing the 3-bit predicate against the zero, carry and sign flags, and it forms the 32-bit effective value (an address or a data word). In standard format that value is the source register plus the sign-extended 16-bit operand. In long format it is the sign-extended 20-bit operand alone. Source register 0 contributes zero, so direct and immediate addressing fall out of the same adder. The register holding the program counter contributes the 20-bit counter, zero-extended.

There is no clock and no handshake. Every output follows the inputs in the same cycle, and the surrounding pipeline registers them as it needs.

Top module: `pdec_top`

## Requirements
- R1: In standard format (long_i=0) the outputs are pred_o=instr_i[31:29], opc_o=instr_i[28:24], rd_o=instr_i[23:20], rs_o=instr_i[19:16] and imm16_o=instr_i[15:0].
- R2: In long format (long_i=1), pred_o, opc_o and rd_o come from the same bits as in R1, imm20_o=instr_i[19:0] and rs_o is 0. In standard format imm20_o still shows instr_i[19:0].
- R3: The flags are flags_i[0]=Z, [1]=C, [2]=S and [3]=V. exec_o is 1 for predicate 000, 0 for 001, Z for 010, !Z for 011, C for 100, !C for 101, S for 110 and !S for 111.
- R4: The overflow flag flags_i[3] has no effect on exec_o for any predicate.
- R5: In standard format with a source that is neither register 0 nor PC_REG, eff_o = rs_val_i + sign-extended instr_i[15:0], modulo 2^32. The carry out is dropped.
- R6: In long format, eff_o is instr_i[19:0] sign-extended to 32 bits and does not depend on rs_val_i or pc_i.
- R7: In standard format with source register 0, eff_o is the sign-extended 16-bit operand, whatever rs_val_i holds.
- R8: In standard format with source register PC_REG (default 15), the source value is {12'b0, pc_i}, so bits [31:20] of that operand are zero and rs_val_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| long_i | input | 1 | 1 selects the long (20-bit operand) format |
| rs_val_i | input | 32 | Value read from the source register |
| pc_i | input | 20 | Current program counter |
| flags_i | input | 4 | Status flags: [0] Z, [1] C, [2] S, [3] V |
| pred_o | output | 3 | Predicate field |
| opc_o | output | 5 | Operation code field |
| rd_o | output | 4 | Destination register number |
| rs_o | output | 4 | Source register number (0 in long format) |
| imm16_o | output | 16 | Standard-format operand field |
| imm20_o | output | 20 | Long-format operand field |
| exec_o | output | 1 | Predicate satisfied: instruction executes |
| eff_o | output | 32 | Effective address or data value |

## Verification
The bench aims at the sign boundaries of both operand widths (0x7FFF against 0x8000, 0x7FFFF against 0x80000). Getting either wrong would zero-fill or extend from the wrong bit. It also drives additions that wrap past 2^32 and would expose a carry leaking into the result. Every predicate is tried against all sixteen flag patterns, V included. A decoder that tested the overflow flag, or inverted the wrong half of a predicate pair, would flip exec_o. Register 0 and the counter register are fed garbage on rs_val_i, and long format is fed garbage on both rs_val_i and pc_i. A design that let those through would show the garbage in eff_o.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam int WORD_W = 32;
  localparam int PRED_W = 3;
  localparam int OPC_W  = 5;
  localparam int REG_W  = 4;
  localparam int IMM_W  = 16;
  localparam int LIMM_W = 20;
  localparam int FLAG_W = 4;

  typedef enum logic [PRED_W-1:0] {
    PR_ALWAYS = 3'd0,
    PR_NEVER  = 3'd1,
    PR_Z      = 3'd2,
    PR_NZ     = 3'd3,
    PR_C      = 3'd4,
    PR_NC     = 3'd5,
    PR_S      = 3'd6,
    PR_NS     = 3'd7
  } pred_e;

  typedef struct packed {
    logic v;
    logic s;
    logic c;
    logic z;
  } flags_t;

  function automatic logic [WORD_W-1:0] sext16(input logic [IMM_W-1:0] x);
    return {{(WORD_W-IMM_W){x[IMM_W-1]}}, x};
  endfunction

  function automatic logic [WORD_W-1:0] sext20(input logic [LIMM_W-1:0] x);
    return {{(WORD_W-LIMM_W){x[LIMM_W-1]}}, x};
  endfunction
endpackage

// File: rtl/pdec_split.sv
module pdec_split
  import pdec_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  input  logic              long_fmt,
  output logic [PRED_W-1:0] pred,
  output logic [OPC_W-1:0]  opc,
  output logic [REG_W-1:0]  rd,
  output logic [REG_W-1:0]  rs,
  output logic [IMM_W-1:0]  imm16,
  output logic [LIMM_W-1:0] imm20
);
  localparam int PRED_LO = WORD_W - PRED_W;
  localparam int OPC_LO  = PRED_LO - OPC_W;
  localparam int RD_LO   = OPC_LO - REG_W;
  localparam int RS_LO   = RD_LO - REG_W;

  always_comb begin
    pred  = instr[WORD_W-1:PRED_LO];
    opc   = instr[PRED_LO-1:OPC_LO];
    rd    = instr[OPC_LO-1:RD_LO];
    rs    = long_fmt ? '0 : instr[RD_LO-1:RS_LO];
    imm16 = instr[IMM_W-1:0];
    imm20 = instr[LIMM_W-1:0];
  end

  // R2: the long format exposes no source register
  always_comb begin
    if (!$isunknown({long_fmt, instr}))
      p_long_no_src_r2: assert (!long_fmt || rs == '0);
  end
endmodule

// File: rtl/pdec_pred.sv
module pdec_pred
  import pdec_pkg::*;
(
  input  logic [PRED_W-1:0] pred,
  input  flags_t            flags,
  output logic              exec_en
);
  logic base;

  always_comb begin
    unique case (pred[PRED_W-1:1])
      2'd0:    base = 1'b1;
      2'd1:    base = flags.z;
      2'd2:    base = flags.c;
      default: base = flags.s;
    endcase
    exec_en = base ^ pred[0];
  end

  always_comb begin
    if (!$isunknown({pred, flags})) begin
      p_always_on_r3:  assert (pred != PR_ALWAYS || exec_en);
      p_never_off_r3:  assert (pred != PR_NEVER || !exec_en);
      p_zero_pair_r3:  assert (pred != PR_Z  || exec_en == flags.z);
      p_sign_pair_r3:  assert (pred != PR_NS || exec_en == !flags.s);
    end
  end
endmodule

// File: rtl/pdec_eff.sv
module pdec_eff
  import pdec_pkg::*;
#(
  parameter int PC_REG = 15,
  parameter int PC_W   = LIMM_W
) (
  input  logic              long_fmt,
  input  logic [REG_W-1:0]  rs,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [LIMM_W-1:0] imm20,
  input  logic [WORD_W-1:0] rs_val,
  input  logic [PC_W-1:0]   pc,
  output logic [WORD_W-1:0] eff
);
  logic [WORD_W-1:0] src_val;
  logic [WORD_W:0]   sum_wide;

  always_comb begin
    if (rs == '0)
      src_val = '0;
    else if (rs == REG_W'(PC_REG))
      src_val = {{(WORD_W-PC_W){1'b0}}, pc};
    else
      src_val = rs_val;
    sum_wide = {1'b0, src_val} + {1'b0, sext16(imm16)};
    eff = long_fmt ? sext20(imm20) : sum_wide[WORD_W-1:0];
  end

  always_comb begin
    if (!$isunknown({long_fmt, rs, imm16, imm20, rs_val, pc})) begin
      // R6: long result is a clean sign extension of the 20-bit field
      p_long_sext_r6: assert (!long_fmt ||
        $countones(eff[WORD_W-1:LIMM_W-1]) == 0 ||
        $countones(eff[WORD_W-1:LIMM_W-1]) == WORD_W-LIMM_W+1);
      // R8: the counter copy never carries upper bits
      p_pc_hi_zero_r8: assert (rs != REG_W'(PC_REG) || src_val[WORD_W-1:PC_W] == '0);
      // R7: register 0 leaves the low half equal to the operand
      p_src0_low_r7: assert (long_fmt || rs != '0 || eff[IMM_W-1:0] == imm16);
    end
  end
endmodule

// File: rtl/pdec_top.sv
module pdec_top
  import pdec_pkg::*;
#(
  parameter int PC_REG = 15
) (
  input  logic [31:0] instr_i,
  input  logic        long_i,
  input  logic [31:0] rs_val_i,
  input  logic [19:0] pc_i,
  input  logic [3:0]  flags_i,
  output logic [2:0]  pred_o,
  output logic [4:0]  opc_o,
  output logic [3:0]  rd_o,
  output logic [3:0]  rs_o,
  output logic [15:0] imm16_o,
  output logic [19:0] imm20_o,
  output logic        exec_o,
  output logic [31:0] eff_o
);
  logic [PRED_W-1:0] pred_w;
  logic [REG_W-1:0]  rs_w;
  logic [IMM_W-1:0]  imm16_w;
  logic [LIMM_W-1:0] imm20_w;
  flags_t            flags_w;

  assign flags_w = flags_i;

  pdec_split u_split (
    .instr    (instr_i),
    .long_fmt (long_i),
    .pred     (pred_w),
    .opc      (opc_o),
    .rd       (rd_o),
    .rs       (rs_w),
    .imm16    (imm16_w),
    .imm20    (imm20_w)
  );

  pdec_pred u_pred (
    .pred    (pred_w),
    .flags   (flags_w),
    .exec_en (exec_o)
  );

  pdec_eff #(.PC_REG(PC_REG), .PC_W(LIMM_W)) u_eff (
    .long_fmt (long_i),
    .rs       (rs_w),
    .imm16    (imm16_w),
    .imm20    (imm20_w),
    .rs_val   (rs_val_i),
    .pc       (pc_i),
    .eff      (eff_o)
  );

  assign pred_o  = pred_w;
  assign rs_o    = rs_w;
  assign imm16_o = imm16_w;
  assign imm20_o = imm20_w;
endmodule

// File: tb/pdec_top_bench.sv
`timescale 1ns/1ps
module pdec_top_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instr;
  logic        lng;
  logic [31:0] rsv;
  logic [19:0] pc;
  logic [3:0]  flg;
  logic [2:0]  pred_o;
  logic [4:0]  opc_o;
  logic [3:0]  rd_o, rs_o;
  logic [15:0] imm16_o;
  logic [19:0] imm20_o;
  logic        exec_o;
  logic [31:0] eff_o;

  int n_chk = 0, n_bad = 0;

  pdec_top u_pdec_top (
    .instr_i(instr), .long_i(lng), .rs_val_i(rsv), .pc_i(pc), .flags_i(flg),
    .pred_o(pred_o), .opc_o(opc_o), .rd_o(rd_o), .rs_o(rs_o),
    .imm16_o(imm16_o), .imm20_o(imm20_o), .exec_o(exec_o), .eff_o(eff_o)
  );

  function automatic logic ref_exec(input logic [2:0] p, input logic [3:0] f);
    case (p)
      3'd0: return 1'b1;
      3'd1: return 1'b0;
      3'd2: return f[0];
      3'd3: return !f[0];
      3'd4: return f[1];
      3'd5: return !f[1];
      3'd6: return f[2];
      default: return !f[2];
    endcase
  endfunction

  function automatic logic [31:0] ref_eff(input logic [31:0] i, input logic l,
                                          input logic [31:0] r, input logic [19:0] p);
    logic [31:0] src;
    if (l) return {{12{i[19]}}, i[19:0]};
    if (i[19:16] == 4'd0) src = 32'd0;
    else if (i[19:16] == 4'd15) src = {12'd0, p};
    else src = r;
    return src + {{16{i[15]}}, i[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic l, input logic [31:0] r,
                       input logic [19:0] p, input logic [3:0] f);
    @(negedge clk);
    instr = i; lng = l; rsv = r; pc = p; flg = f;
    #1;
  endtask

  task automatic check_all();
    chk("R1 pred", {29'd0, pred_o}, {29'd0, instr[31:29]});
    chk("R1 opc",  {27'd0, opc_o},  {27'd0, instr[28:24]});
    chk("R1 rd",   {28'd0, rd_o},   {28'd0, instr[23:20]});
    chk(lng ? "R2 rs" : "R1 rs", {28'd0, rs_o}, lng ? 32'd0 : {28'd0, instr[19:16]});
    chk("R1 imm16", {16'd0, imm16_o}, {16'd0, instr[15:0]});
    chk("R2 imm20", {12'd0, imm20_o}, {12'd0, instr[19:0]});
    chk("R3 exec", {31'd0, exec_o}, {31'd0, ref_exec(instr[31:29], flg)});
    chk(lng ? "R6 eff" : "R5 eff", eff_o, ref_eff(instr, lng, rsv, pc));
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    instr = '0; lng = 0; rsv = '0; pc = '0; flg = '0;
    // idle state: all-zero inputs
    apply(32'h0, 0, 32'h0, 20'h0, 4'h0);
    check_all();
    chk("R5 zero", eff_o, 32'h0);

    // R3/R4: every predicate against every flag pattern
    for (int p = 0; p < 8; p++)
      for (int f = 0; f < 16; f++) begin
        apply({p[2:0], 29'h0}, 0, 32'h0, 20'h0, f[3:0]);
        chk("R3 table", {31'd0, exec_o}, {31'd0, ref_exec(p[2:0], f[3:0])});
        if (f >= 8)
          chk("R4 overflow ignored", {31'd0, exec_o},
              {31'd0, ref_exec(p[2:0], f[3:0] & 4'h7)});
      end

    // R5 sign boundary and wrap
    apply(32'h0013_7FFF, 0, 32'h0000_0001, 20'h0, 4'h0);
    chk("R5 pos edge", eff_o, 32'h0000_8000);
    apply(32'h0013_8000, 0, 32'h0000_0000, 20'h0, 4'h0);
    chk("R5 neg edge", eff_o, 32'hFFFF_8000);
    apply(32'h0013_0001, 0, 32'hFFFF_FFFF, 20'h0, 4'h0);
    chk("R5 wrap", eff_o, 32'h0000_0000);
    apply(32'h0013_FFFF, 0, 32'h0000_0005, 20'h0, 4'h0);
    chk("R5 minus one", eff_o, 32'h0000_0004);

    // R6 boundaries with garbage source and pc
    apply(32'h0017_FFFF, 1, 32'hDEAD_BEEF, 20'hABCDE, 4'h0);
    chk("R6 pos edge", eff_o, 32'h0007_FFFF);
    apply(32'h0018_0000, 1, 32'hDEAD_BEEF, 20'hABCDE, 4'h0);
    chk("R6 neg edge", eff_o, 32'hFFF8_0000);
    chk("R2 rs long", {28'd0, rs_o}, 32'd0);

    // R7 register 0 ignores rs_val
    apply(32'h0000_1234, 0, 32'hCAFE_F00D, 20'h0, 4'h0);
    chk("R7 direct", eff_o, 32'h0000_1234);
    apply(32'h0000_C000, 0, 32'h1111_1111, 20'h0, 4'h0);
    chk("R7 neg immediate", eff_o, 32'hFFFF_C000);

    // R8 counter register
    apply(32'h000F_0000, 0, 32'hFFFF_FFFF, 20'hFFFFF, 4'h0);
    chk("R8 pc copy", eff_o, 32'h000F_FFFF);
    apply(32'h000F_0010, 0, 32'h1234_5678, 20'h00100, 4'h0);
    chk("R8 pc offset", eff_o, 32'h0000_0110);

    // random mix
    for (int k = 0; k < 400; k++) begin
      apply($urandom, 1'($urandom), $urandom, 20'($urandom), 4'($urandom));
      check_all();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule